// File: doc/BRIEF.md
# Interrupt Flag Privilege Controller

This block carries out the clear-interrupt and set-interrupt operations of a processor core. It owns the interrupt-enable bit (IF) and the virtual interrupt-enable bit (VIF) of the flags word. For each request it checks the operating mode, the current privilege level, the I/O privilege field and the virtual-interrupt controls. From that check it writes IF, redirects the write to VIF, or raises a general-protection fault whose error code is zero.

A set that turns IF on also starts an interrupt shadow. The inhibit output rises and a one-cycle asynchronous-event strobe fires, so that interrupts stay blocked until one more instruction has retired. The block takes at most one request per cycle. All of its outputs are registered and reflect a request on the cycle after it is presented.

Top module: `intflag_priv_ctrl`

## Requirements
- R1: After reset, if_q, vif_q, inhibit_q, gp_fault and async_evt are all 0. A request sampled at a clock edge shows its effect on the outputs right after that same edge, which is one cycle after it was presented.
- R2: With op_mode 2'b00 (real) or 2'b11 (treated as real), a request with req_set=0 writes if_q to 0 and a request with req_set=1 writes if_q to 1. Neither raises a fault.
- R3: With op_mode 2'b01 (protected), pvi_en=1, cpl=3 and iopl<3, a clear request writes vif_q to 0 without a fault and leaves if_q unchanged.
- R4: With op_mode 2'b01 outside the R3/R5 condition, a clear or set request with cpl>iopl faults. Otherwise it writes if_q.
- R5: Under the R3 condition, a set request with vip=0 writes vif_q to 1 and a set request with vip=1 faults.
- R6: With op_mode 2'b10 (virtual-8086) and iopl!=3, a clear request writes vif_q to 0 when vme_en=1 and faults when vme_en=0.
- R7: With op_mode 2'b10 and iopl!=3, a set request writes vif_q to 1 only when vme_en=1 and vip=0, and faults otherwise. With iopl=3, requests act on if_q.
- R8: A fault shows as gp_fault high for exactly one cycle per faulting request, with gp_code equal to zero. if_q and vif_q keep their prior values.
- R9: A set that acts on IF while if_q=0 raises inhibit_q and pulses async_evt for one cycle.
- R10: A set that acts on IF while if_q=1 neither pulses async_evt nor re-arms inhibit_q.
- R11: inhibit_q falls on the edge after a cycle in which retire=1 while it was high. An arming set in that same cycle keeps it high.
- R12: With req_valid=0, if_q and vif_q do not change, and gp_fault and async_evt stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_set | input | 1 | 1 = set-interrupt, 0 = clear-interrupt |
| op_mode | input | 2 | 00 real, 01 protected, 10 virtual-8086, 11 as real |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege field of the flags word |
| vme_en | input | 1 | Virtual-8086 virtual-interrupt extensions enabled |
| pvi_en | input | 1 | Protected-mode virtual interrupts enabled |
| vip | input | 1 | Virtual interrupt pending bit |
| retire | input | 1 | One-cycle pulse per retired instruction |
| if_q | output | 1 | Interrupt-enable bit |
| vif_q | output | 1 | Virtual interrupt-enable bit |
| gp_fault | output | 1 | General-protection fault strobe |
| gp_code | output | ERR_W | Fault error code (always zero) |
| inhibit_q | output | 1 | Interrupt shadow active |
| async_evt | output | 1 | Pending asynchronous event strobe |

## Verification
The assertions assume that the mode, privilege and control inputs are stable, known values whenever req_valid is high. They also assume that retire is a synchronous level sampled once per edge. The bench drives every input only on the falling clock edge, so each input is settled well before the rising edge that samples it. Directed phases walk each decision branch. A long pseudo-random phase then covers every combination of mode, privilege and controls, with idle cycles and retire pulses mixed in.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_MAX = '1;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10,
    MODE_ALT  = 2'b11
  } opmode_e;

  typedef enum logic [1:0] {
    TGT_IF    = 2'b00,
    TGT_VIF   = 2'b01,
    TGT_FAULT = 2'b10
  } target_e;

  // Virtual redirect in protected mode: most-restricted ring with lowered I/O privilege
  function automatic logic prot_virtual(input logic pvi,
                                        input logic [PRIV_W-1:0] cpl,
                                        input logic [PRIV_W-1:0] iopl);
    return pvi && (cpl == PRIV_MAX) && (iopl < PRIV_MAX);
  endfunction

  function automatic target_e pick_target(input logic is_set,
                                          input opmode_e mode,
                                          input logic [PRIV_W-1:0] cpl,
                                          input logic [PRIV_W-1:0] iopl,
                                          input logic vme,
                                          input logic pvi,
                                          input logic pend);
    target_e t;
    t = TGT_IF;
    case (mode)
      MODE_PROT: begin
        if (prot_virtual(pvi, cpl, iopl))
          t = (is_set && pend) ? TGT_FAULT : TGT_VIF;
        else if (cpl > iopl)
          t = TGT_FAULT;
      end
      MODE_V86: begin
        if (iopl != PRIV_MAX) begin
          if (!vme || (is_set && pend)) t = TGT_FAULT;
          else                          t = TGT_VIF;
        end
      end
      default: t = TGT_IF;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/intflag_decide.sv
module intflag_decide
  import intflag_pkg::*;
(
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_set,
  input  opmode_e           mode,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  input  logic              vme_en,
  input  logic              pvi_en,
  input  logic              vip,
  output target_e           target,
  output logic              virt_path
);
  always_comb begin
    target    = pick_target(req_set, mode, cpl, iopl, vme_en, pvi_en, vip);
    virt_path = (mode == MODE_PROT) ? prot_virtual(pvi_en, cpl, iopl)
              : ((mode == MODE_V86) && (iopl != PRIV_MAX));
  end

  always_comb begin
    // R2
    if (rst_n && req_valid && (mode == MODE_REAL || mode == MODE_ALT))
      real_if_chk: assert (target == TGT_IF);
    // R7
    if (rst_n && req_valid && !virt_path && mode == MODE_V86)
      v86_open_chk: assert (target == TGT_IF);
  end
endmodule

// File: rtl/intflag_state.sv
module intflag_state
  import intflag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_set,
  input  target_e target,
  output logic    if_q,
  output logic    vif_q,
  output logic    gp_fault,
  output logic    async_evt,
  output logic    arm
);
  logic wr_if, wr_vif, raise;

  always_comb begin
    wr_if  = req_valid && (target == TGT_IF);
    wr_vif = req_valid && (target == TGT_VIF);
    raise  = req_valid && (target == TGT_FAULT);
    arm    = wr_if && req_set && !if_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q      <= 1'b0;
      vif_q     <= 1'b0;
      gp_fault  <= 1'b0;
      async_evt <= 1'b0;
    end else begin
      if (wr_if)  if_q  <= req_set;
      if (wr_vif) vif_q <= req_set;
      gp_fault  <= raise;
      async_evt <= arm;
    end
  end

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> ($stable(if_q) && $stable(vif_q)));
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(if_q) && $stable(vif_q) && !gp_fault && !async_evt));
  // R10
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_set && if_q) |=> !async_evt);
  // R9
  async_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_evt |-> (if_q && !$past(if_q)));
endmodule

// File: rtl/intflag_inhibit.sv
module intflag_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic retire,
  output logic inhibit_q
);
  logic release_now;
  assign release_now = inhibit_q && retire;

  always_ff @(posedge clk) begin
    if (!rst_n)           inhibit_q <= 1'b0;
    else if (arm)         inhibit_q <= 1'b1;
    else if (release_now) inhibit_q <= 1'b0;
  end

  // R9
  inh_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> inhibit_q);
  // R11
  inh_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && retire && !arm) |=> !inhibit_q);
endmodule

// File: rtl/intflag_priv_ctrl.sv
module intflag_priv_ctrl
  import intflag_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_set,
  input  logic [1:0]        op_mode,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] iopl,
  input  logic              vme_en,
  input  logic              pvi_en,
  input  logic              vip,
  input  logic              retire,
  output logic              if_q,
  output logic              vif_q,
  output logic              gp_fault,
  output logic [ERR_W-1:0]  gp_code,
  output logic              inhibit_q,
  output logic              async_evt
);
  target_e target;
  logic    virt_path;
  logic    arm;

  intflag_decide u_decide (
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_set   (req_set),
    .mode      (opmode_e'(op_mode)),
    .cpl       (cpl),
    .iopl      (iopl),
    .vme_en    (vme_en),
    .pvi_en    (pvi_en),
    .vip       (vip),
    .target    (target),
    .virt_path (virt_path)
  );

  intflag_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_set   (req_set),
    .target    (target),
    .if_q      (if_q),
    .vif_q     (vif_q),
    .gp_fault  (gp_fault),
    .async_evt (async_evt),
    .arm       (arm)
  );

  intflag_inhibit u_inhibit (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .retire    (retire),
    .inhibit_q (inhibit_q)
  );

  assign gp_code = '0;

  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gp_fault && async_evt));
  // R9
  async_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_evt |-> inhibit_q);
endmodule

// File: tb/intflag_priv_ctrl_tb.sv
module intflag_priv_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int ERR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_set = 1'b0, vme_en = 1'b0, pvi_en = 1'b0, vip = 1'b0, retire = 1'b0;
  logic [1:0] op_mode = 2'b00, cpl = 2'b00, iopl = 2'b00;
  logic if_q, vif_q, gp_fault, inhibit_q, async_evt;
  logic [ERR_W-1:0] gp_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  intflag_priv_ctrl #(.ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .op_mode(op_mode), .cpl(cpl), .iopl(iopl), .vme_en(vme_en), .pvi_en(pvi_en),
    .vip(vip), .retire(retire), .if_q(if_q), .vif_q(vif_q), .gp_fault(gp_fault),
    .gp_code(gp_code), .inhibit_q(inhibit_q), .async_evt(async_evt)
  );

  // Behavioural reference: 0 = write IF, 1 = write VIF, 2 = fault
  bit m_if, m_vif, m_fault, m_async, m_inh;
  int m_act;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_if = 0; m_vif = 0; m_fault = 0; m_async = 0; m_inh = 0;
    end else begin
      m_fault = 0;
      m_async = 0;
      if (retire && m_inh) m_inh = 0;
      if (req_valid) begin
        m_act = 0;
        if (op_mode == 2'b01) begin
          if (pvi_en && cpl == 3 && iopl != 3) m_act = (req_set && vip) ? 2 : 1;
          else if (int'(cpl) > int'(iopl))     m_act = 2;
        end else if (op_mode == 2'b10 && iopl != 3) begin
          if (vme_en && !(req_set && vip)) m_act = 1;
          else                             m_act = 2;
        end
        if (m_act == 2)      m_fault = 1;
        else if (m_act == 1) m_vif = req_set;
        else begin
          if (req_set && !m_if) begin m_inh = 1; m_async = 1; end
          m_if = req_set;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("if_q", if_q, m_if);
      chk("vif_q", vif_q, m_vif);
      chk("gp_fault", gp_fault, m_fault);
      chk("async_evt", async_evt, m_async);
      chk("inhibit_q", inhibit_q, m_inh);
      chk("gp_code", int'(gp_code), 0);
    end
  end

  task automatic go(input bit s, input logic [1:0] md, input logic [1:0] c,
                    input logic [1:0] io, input bit vm, input bit pv, input bit vp);
    req_valid = 1; req_set = s; op_mode = md; cpl = c; iopl = io;
    vme_en = vm; pvi_en = pv; vip = vp; retire = 0;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n, input bit ret);
    for (int i = 0; i < n; i++) begin
      req_valid = 0; retire = ret;
      @(negedge clk);
    end
    retire = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; @(negedge clk);
    chk("R1 if_q reset", if_q, 0);
    chk("R1 inhibit_q reset", inhibit_q, 0);

    cur_req = "R2";
    go(1, 2'b00, 0, 0, 0, 0, 0);     // IF 0->1, arms (R9)
    chk("R2 real set", if_q, 1);
    cur_req = "R11"; idle(1, 1); idle(1, 0);
    chk("R11 released", inhibit_q, 0);
    cur_req = "R10";
    go(1, 2'b11, 0, 0, 0, 0, 0);
    chk("R10 no async", async_evt, 0);
    chk("R10 no inhibit", inhibit_q, 0);
    cur_req = "R2";
    go(0, 2'b11, 2, 0, 1, 1, 1);
    chk("R2 alt clear", if_q, 0);
    cur_req = "R9";
    go(1, 2'b00, 0, 0, 0, 0, 0);
    chk("R9 inhibit", inhibit_q, 1);
    // R11: retire together with a new arming set keeps inhibit up
    cur_req = "R11";
    go(0, 2'b00, 0, 0, 0, 0, 0);
    req_valid = 1; req_set = 1; op_mode = 2'b00; retire = 1;
    @(negedge clk); req_valid = 0; retire = 0;
    chk("R11 rearm holds", inhibit_q, 1);
    idle(2, 0);
    chk("R11 no retire holds", inhibit_q, 1);
    idle(1, 1);

    cur_req = "R5";
    go(1, 2'b01, 3, 0, 0, 1, 0);
    chk("R5 vif set", vif_q, 1);
    go(1, 2'b01, 3, 2, 0, 1, 1);
    chk("R5 vip fault", gp_fault, 1);
    cur_req = "R8"; @(negedge clk);
    chk("R8 one-cycle strobe", gp_fault, 0);
    cur_req = "R3";
    go(0, 2'b01, 3, 1, 0, 1, 1);
    chk("R3 vif clear", vif_q, 0);
    chk("R3 if kept", if_q, 1);
    cur_req = "R4";
    go(1, 2'b01, 2, 1, 1, 1, 0);
    chk("R4 fault", gp_fault, 1);
    go(0, 2'b01, 1, 1, 0, 0, 0);
    chk("R4 if clear", if_q, 0);
    go(1, 2'b01, 3, 3, 0, 1, 1);
    chk("R4 ring3 iopl3 set", if_q, 1);
    go(0, 2'b01, 3, 0, 0, 0, 0);
    chk("R4 no pvi fault", gp_fault, 1);

    cur_req = "R6";
    go(0, 2'b10, 3, 1, 0, 0, 0);
    chk("R6 no vme fault", gp_fault, 1);
    go(1, 2'b10, 3, 0, 1, 0, 0);
    go(0, 2'b10, 3, 0, 1, 0, 1);
    chk("R6 vif clear", vif_q, 0);
    cur_req = "R7";
    go(1, 2'b10, 3, 2, 1, 0, 1);
    chk("R7 vip fault", gp_fault, 1);
    go(1, 2'b10, 3, 2, 1, 0, 0);
    chk("R7 vif set", vif_q, 1);
    go(0, 2'b10, 3, 3, 0, 0, 0);
    chk("R7 iopl3 acts on IF", if_q, 0);

    cur_req = "R12";
    for (int i = 0; i < 40; i++) begin
      req_valid = 0; req_set = $urandom; op_mode = $urandom; cpl = $urandom;
      iopl = $urandom; vme_en = $urandom; pvi_en = $urandom; vip = $urandom;
      retire = $urandom;
      @(negedge clk);
    end
    retire = 0;

    cur_req = "R8 random";
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 4) != 0; req_set = $urandom; op_mode = $urandom;
      cpl = $urandom; iopl = $urandom; vme_en = $urandom; pvi_en = $urandom;
      vip = $urandom; retire = ($urandom % 3) == 0;
      @(negedge clk);
    end
    req_valid = 0; retire = 0;
    @(negedge clk);
    finish_run();
  end
endmodule